// File: doc/BRIEF.md
# Block-Cipher Register Front-End

This block is the software-facing register bank placed in front of a block-cipher engine. A simple word-addressed register bus writes a configuration word, a control strobe register, a completion flag, a data-word pointer, a single data port into a 128-bit working buffer, a write-only 128-bit initialization vector and up to eight key words. The block drives the engine with a one-cycle start pulse, the buffer contents, the initialization vector, the key words and the configuration word. It takes a busy level, a done pulse and a 128-bit result back from the engine.

The working buffer holds both the input and the output. When the engine reports done, its result replaces the buffer in place, and software reads the result back through the same pointer-indexed data port. An operation starts in one of two ways. In manual mode software writes a go bit. In automatic mode the operation starts by itself on the write that fills the buffer. While the enable bit is set, the configuration word is locked.

Top module: `cipher_regfront`

## Requirements
- R1: Word addresses: 0x00 config, 0x01 control, 0x02 flag, 0x03 pointer, 0x04 data port, 0x08–0x0B initialization vector words 0–3, 0x10–0x17 key words 0–7. Every read or write at 0x04 touches the buffer word selected by the pointer, then advances the pointer by one, wrapping from 3 to 0. The pointer reads back at 0x03, and a write there loads bits 1:0.
- R2: Buffer word i drives `eng_din[32i+31:32i]`. When `eng_done` is seen, `eng_result` replaces the whole buffer, and the new words are read back through the data port.
- R3: Any read of the data port while an operation is in progress returns zero. An operation is in progress from the start pulse until done, or while `eng_busy` is high.
- R4: In manual mode (config bit 11 = 0), with enable set (config bit 1) and no operation in progress, writing 1 to control bit 0 produces a one-cycle `eng_start` pulse after that clock edge and clears the completion flag.
- R5: In automatic mode (config bit 11 = 1), with enable set, the fourth data-port write counted since the last reset of the fill counter starts the engine without any control write. The fill counter is reset by a pointer write and by writing 1 to control bit 1 (new message).
- R6: While config bit 1 is set, a config write changes only bits 1 and 0. All other fields keep their values.
- R7: When the block is disabled, a config write stores bits 19:16 and 14:1. Bits 15 and 31:20 always read as zero.
- R8: Initialization vector word i drives `eng_iv[32i+31:32i]`, and key word i drives `eng_key[32i+31:32i]`. Reads at their addresses return zero.
- R9: The completion flag (flag register bit 0, also `done_flag`) is set on `eng_done`. Writing 1 to bit 0 clears it, and writing 0 has no effect.
- R10: With config bit 14 set, a key-word write XORs the written value into the stored word. With bit 14 clear, the write replaces the stored word.
- R11: A config write with bit 0 set returns every register, the pointer, the fill counter, the buffer, the initialization vector, the key words and the flag to zero at that clock edge. Bit 0 never reads back as 1.
- R12: A control go write is ignored while the block is disabled or while an operation is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (data-port reads advance the pointer) |
| reg_addr | input | ADDR_W | Word address |
| reg_wdata | input | WORD_W | Write data |
| reg_rdata | output | WORD_W | Read data, combinational from address and strobe |
| eng_start | output | 1 | One-cycle start pulse to the engine |
| eng_busy | input | 1 | Engine busy level |
| eng_done | input | 1 | Engine done pulse, qualifies eng_result |
| eng_result | input | DATA_WORDS*WORD_W | Engine result written back into the buffer |
| eng_cfg | output | WORD_W | Configuration word |
| eng_din | output | DATA_WORDS*WORD_W | Working buffer contents |
| eng_iv | output | IV_WORDS*WORD_W | Initialization vector |
| eng_key | output | KEY_WORDS*WORD_W | Key words |
| done_flag | output | 1 | Completion flag |

## Verification
The hardest case to reach is a new-message strobe arriving partway through an automatic fill. Without it the block would start on a write count that spans two messages. The stimulus writes three words, issues the strobe and writes three more, then checks that no start occurred. It then confirms that exactly one further write launches the engine, and that the result lands in the pointer-selected words after the pointer has wrapped. The blanking window of the data port is reached by reading in the cycle right after a manual go, while the engine stub is still counting its latency.

// File: rtl/cfr_pkg.sv
package cfr_pkg;

   // register word addresses
   localparam int unsigned A_CFG      = 0;
   localparam int unsigned A_CTRL     = 1;
   localparam int unsigned A_FLAG     = 2;
   localparam int unsigned A_PTR      = 3;
   localparam int unsigned A_DATA     = 4;
   localparam int unsigned A_IV_BASE  = 8;
   localparam int unsigned A_KEY_BASE = 16;

   // config word bit positions decoded by the engine and by this block
   localparam int unsigned CB_SRST = 0;
   localparam int unsigned CB_EN   = 1;
   localparam int unsigned CB_AUTO = 11;
   localparam int unsigned CB_XOR  = 14;

   // bits that a config write may store (soft reset never stored)
   localparam logic [31:0] CFG_STORE_MASK = 32'h000F_7FFE;
   localparam logic [31:0] CFG_EN_MASK    = 32'h0000_0002;

   // control register bits
   localparam int unsigned CT_GO     = 0;
   localparam int unsigned CT_NEWMSG = 1;

   typedef struct packed {
      logic        wr;
      logic        rd;
      logic [31:0] wdata;
   } cfr_req_t;

endpackage

// File: rtl/cfr_cfg_reg.sv
module cfr_cfg_reg
   import cfr_pkg::*;
#(
   parameter int unsigned WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              wr,
   input  logic [WORD_W-1:0] wdata,
   output logic [WORD_W-1:0] cfg_q
);

   localparam logic [WORD_W-1:0] STORE = WORD_W'(CFG_STORE_MASK);
   localparam logic [WORD_W-1:0] ENM   = WORD_W'(CFG_EN_MASK);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else if (clr) begin
         cfg_q <= '0;
      end else if (wr) begin
         if (cfg_q[CB_EN])
            cfg_q <= (cfg_q & ~ENM) | (wdata & ENM);
         else
            cfg_q <= wdata & STORE;
      end
   end

   // R6: locked fields hold across a write while enabled
   p_cfg_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && wr && cfg_q[CB_EN]) |=> ((cfg_q & ~ENM) == ($past(cfg_q) & ~ENM)));

   // R11: soft reset bit is never visible
   p_srst_hidden_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_q[CB_SRST]);

endmodule

// File: rtl/cfr_word_bank.sv
module cfr_word_bank #(
   parameter int unsigned WORD_W = 32,
   parameter int unsigned WORDS  = 4,
   parameter bit          XOR_EN = 1'b0,
   localparam int unsigned IW    = $clog2(WORDS)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clr,
   input  logic                    wr,
   input  logic [IW-1:0]           idx,
   input  logic [WORD_W-1:0]       wdata,
   input  logic                    xor_mode,
   output logic [WORDS*WORD_W-1:0] flat
);

   for (genvar i = 0; i < WORDS; i++) begin : g_word
      logic [WORD_W-1:0] q;
      logic [WORD_W-1:0] nxt;

      if (XOR_EN) begin : g_xor
         assign nxt = xor_mode ? (q ^ wdata) : wdata;
      end else begin : g_plain
         logic unused_mode;
         assign unused_mode = xor_mode;
         assign nxt = wdata;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                      q <= '0;
         else if (clr)                    q <= '0;
         else if (wr && idx == IW'(i))    q <= nxt;
      end

      assign flat[i*WORD_W +: WORD_W] = q;
   end

endmodule

// File: rtl/cfr_data_buf.sv
module cfr_data_buf #(
   parameter int unsigned WORD_W = 32,
   parameter int unsigned WORDS  = 4,
   localparam int unsigned PW    = $clog2(WORDS),
   localparam int unsigned CW    = $clog2(WORDS + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clr,
   input  logic                    ptr_wr,
   input  logic [PW-1:0]           ptr_wdata,
   input  logic                    acc_rd,
   input  logic                    acc_wr,
   input  logic [WORD_W-1:0]       wdata,
   input  logic                    hold,
   input  logic                    newmsg,
   input  logic                    res_load,
   input  logic [WORDS*WORD_W-1:0] res,
   output logic [PW-1:0]           ptr_q,
   output logic [WORD_W-1:0]       rword,
   output logic [WORDS*WORD_W-1:0] flat,
   output logic                    fill_done
);

   localparam logic [PW-1:0] LAST = PW'(WORDS - 1);
   localparam logic [CW-1:0] FULL = CW'(WORDS - 1);

   logic [WORD_W-1:0] mem [WORDS];
   logic [CW-1:0]     cnt_q;
   logic              wr_ok;

   assign wr_ok     = acc_wr && !hold;
   assign fill_done = wr_ok && (cnt_q == FULL);
   assign rword     = mem[ptr_q];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 ptr_q <= '0;
      else if (clr)               ptr_q <= '0;
      else if (ptr_wr)            ptr_q <= ptr_wdata;
      else if (acc_rd || acc_wr)  ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      cnt_q <= '0;
      else if (clr || ptr_wr || newmsg) cnt_q <= '0;
      else if (wr_ok)                  cnt_q <= (cnt_q == FULL) ? '0 : cnt_q + 1'b1;
   end

   for (genvar i = 0; i < WORDS; i++) begin : g_buf
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                        mem[i] <= '0;
         else if (clr)                      mem[i] <= '0;
         else if (res_load)                 mem[i] <= res[i*WORD_W +: WORD_W];
         else if (wr_ok && ptr_q == PW'(i)) mem[i] <= wdata;
      end
      assign flat[i*WORD_W +: WORD_W] = mem[i];
   end

   // R1: each data access steps the pointer with wrap
   p_ptr_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !ptr_wr && (acc_rd || acc_wr)) |=>
         (ptr_q == (($past(ptr_q) == LAST) ? '0 : $past(ptr_q) + 1'b1)));

   // R5: a fill completion always leaves the counter at zero
   p_fill_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      fill_done |=> (cnt_q == '0));

endmodule

// File: rtl/cipher_regfront.sv
module cipher_regfront
   import cfr_pkg::*;
#(
   parameter int unsigned ADDR_W     = 5,
   parameter int unsigned WORD_W     = 32,
   parameter int unsigned DATA_WORDS = 4,
   parameter int unsigned IV_WORDS   = 4,
   parameter int unsigned KEY_WORDS  = 8,
   localparam int unsigned BLK_W     = DATA_WORDS * WORD_W,
   localparam int unsigned IV_W      = IV_WORDS * WORD_W,
   localparam int unsigned KEY_W     = KEY_WORDS * WORD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [WORD_W-1:0] reg_wdata,
   output logic [WORD_W-1:0] reg_rdata,
   output logic              eng_start,
   input  logic              eng_busy,
   input  logic              eng_done,
   input  logic [BLK_W-1:0]  eng_result,
   output logic [WORD_W-1:0] eng_cfg,
   output logic [BLK_W-1:0]  eng_din,
   output logic [IV_W-1:0]   eng_iv,
   output logic [KEY_W-1:0]  eng_key,
   output logic              done_flag
);

   localparam int unsigned PW     = $clog2(DATA_WORDS);
   localparam int unsigned IV_IW  = $clog2(IV_WORDS);
   localparam int unsigned KEY_IW = $clog2(KEY_WORDS);

   localparam logic [ADDR_W-1:0] AD_CFG  = ADDR_W'(A_CFG);
   localparam logic [ADDR_W-1:0] AD_CTRL = ADDR_W'(A_CTRL);
   localparam logic [ADDR_W-1:0] AD_FLAG = ADDR_W'(A_FLAG);
   localparam logic [ADDR_W-1:0] AD_PTR  = ADDR_W'(A_PTR);
   localparam logic [ADDR_W-1:0] AD_DATA = ADDR_W'(A_DATA);
   localparam logic [ADDR_W-1:0] AD_IV   = ADDR_W'(A_IV_BASE);
   localparam logic [ADDR_W-1:0] AD_KEY  = ADDR_W'(A_KEY_BASE);
   localparam logic [ADDR_W:0]   AD_IV_END  = (ADDR_W+1)'(A_IV_BASE + IV_WORDS);
   localparam logic [ADDR_W:0]   AD_KEY_END = (ADDR_W+1)'(A_KEY_BASE + KEY_WORDS);

   // elaboration-time parameter checks
   if (WORD_W != 32) begin : g_bad_word
      $error("cipher_regfront: config layout needs WORD_W of 32");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("cipher_regfront: ADDR_W too small for the register map");
   end
   if (DATA_WORDS < 2) begin : g_bad_data
      $error("cipher_regfront: DATA_WORDS must be at least 2");
   end
   if (IV_WORDS < 2 || A_IV_BASE + IV_WORDS > A_KEY_BASE) begin : g_bad_iv
      $error("cipher_regfront: IV_WORDS out of range");
   end
   if (KEY_WORDS < 2 || A_KEY_BASE + KEY_WORDS > (1 << ADDR_W)) begin : g_bad_key
      $error("cipher_regfront: KEY_WORDS out of range");
   end

   cfr_req_t req;
   assign req.wr    = reg_wr;
   assign req.rd    = reg_rd;
   assign req.wdata = WORD_W'(reg_wdata);

   // address decode
   logic cfg_wr, ctrl_wr, flag_wr, ptr_wr, data_wr, data_rd;
   logic in_iv, in_key, iv_wr, key_wr;

   assign cfg_wr  = req.wr && reg_addr == AD_CFG;
   assign ctrl_wr = req.wr && reg_addr == AD_CTRL;
   assign flag_wr = req.wr && reg_addr == AD_FLAG;
   assign ptr_wr  = req.wr && reg_addr == AD_PTR;
   assign data_wr = req.wr && reg_addr == AD_DATA;
   assign data_rd = req.rd && reg_addr == AD_DATA;
   assign in_iv   = (reg_addr >= AD_IV)  && ({1'b0, reg_addr} < AD_IV_END);
   assign in_key  = (reg_addr >= AD_KEY) && ({1'b0, reg_addr} < AD_KEY_END);
   assign iv_wr   = req.wr && in_iv;
   assign key_wr  = req.wr && in_key;

   // soft reset acts at the edge of the config write that carries it
   logic srst;
   assign srst = cfg_wr && req.wdata[CB_SRST];

   logic [WORD_W-1:0] cfg_q;

   cfr_cfg_reg #(.WORD_W(WORD_W)) u_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (srst),
      .wr    (cfg_wr),
      .wdata (req.wdata),
      .cfg_q (cfg_q)
   );

   // engine handshake state
   logic busy_q, start_q, flag_q;
   logic blank, go_req, newmsg, fill_done, fire_manual, fire_auto, fire;

   assign blank       = busy_q || eng_busy;
   assign go_req      = ctrl_wr && req.wdata[CT_GO];
   assign newmsg      = ctrl_wr && req.wdata[CT_NEWMSG];
   assign fire_manual = go_req && !cfg_q[CB_AUTO];
   assign fire_auto   = fill_done && cfg_q[CB_AUTO];
   assign fire        = cfg_q[CB_EN] && !blank && (fire_manual || fire_auto);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         start_q <= 1'b0;
         flag_q  <= 1'b0;
      end else if (srst) begin
         busy_q  <= 1'b0;
         start_q <= 1'b0;
         flag_q  <= 1'b0;
      end else begin
         start_q <= fire;
         if (fire)          busy_q <= 1'b1;
         else if (eng_done) busy_q <= 1'b0;
         if (eng_done)
            flag_q <= 1'b1;
         else if ((fire && fire_manual) || (flag_wr && req.wdata[0]))
            flag_q <= 1'b0;
      end
   end

   // shared data buffer
   logic [PW-1:0]     ptr_q;
   logic [WORD_W-1:0] rword;

   cfr_data_buf #(.WORD_W(WORD_W), .WORDS(DATA_WORDS)) u_buf (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (srst),
      .ptr_wr    (ptr_wr),
      .ptr_wdata (req.wdata[PW-1:0]),
      .acc_rd    (data_rd),
      .acc_wr    (data_wr),
      .wdata     (req.wdata),
      .hold      (blank),
      .newmsg    (newmsg),
      .res_load  (eng_done),
      .res       (eng_result),
      .ptr_q     (ptr_q),
      .rword     (rword),
      .flat      (eng_din),
      .fill_done (fill_done)
   );

   // write-only banks
   cfr_word_bank #(.WORD_W(WORD_W), .WORDS(IV_WORDS), .XOR_EN(1'b0)) u_iv (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (srst),
      .wr       (iv_wr),
      .idx      (IV_IW'(reg_addr - AD_IV)),
      .wdata    (req.wdata),
      .xor_mode (1'b0),
      .flat     (eng_iv)
   );

   cfr_word_bank #(.WORD_W(WORD_W), .WORDS(KEY_WORDS), .XOR_EN(1'b1)) u_key (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (srst),
      .wr       (key_wr),
      .idx      (KEY_IW'(reg_addr - AD_KEY)),
      .wdata    (req.wdata),
      .xor_mode (cfg_q[CB_XOR]),
      .flat     (eng_key)
   );

   // read mux: banks that are write-only fall through to zero
   always_comb begin
      reg_rdata = '0;
      if (req.rd) begin
         if (reg_addr == AD_CFG)       reg_rdata = cfg_q;
         else if (reg_addr == AD_FLAG) reg_rdata = {{(WORD_W-1){1'b0}}, flag_q};
         else if (reg_addr == AD_PTR)  reg_rdata = WORD_W'(ptr_q);
         else if (reg_addr == AD_DATA) reg_rdata = blank ? '0 : rword;
      end
   end

   assign eng_start = start_q;
   assign eng_cfg   = cfg_q;
   assign done_flag = flag_q;

   // R3: data reads are blanked while an operation runs
   p_read_blank_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (data_rd && (busy_q || eng_busy)) |-> (reg_rdata == '0));

   // R4: start is a single-cycle pulse
   p_start_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |=> !eng_start);

   // R12: no new start while an operation is still open
   p_no_restart_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !eng_done) |=> !eng_start);

   // R9: the flag only rises after a done pulse
   p_flag_from_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_flag) |-> $past(eng_done));

   // R8: write-only banks never leak through the read port
   p_iv_hidden_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (req.rd && (in_iv || in_key)) |-> (reg_rdata == '0));

endmodule

// File: tb/sim_cipher_regfront.sv
module sim_cipher_regfront;

   localparam time CLK_P = 20ns;
   localparam int  LAT   = 5;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         reg_wr = 1'b0;
   logic         reg_rd = 1'b0;
   logic [4:0]   reg_addr = '0;
   logic [31:0]  reg_wdata = '0;
   logic [31:0]  reg_rdata;
   logic         eng_start;
   logic         eng_busy;
   logic         eng_done;
   logic [127:0] eng_result;
   logic [31:0]  eng_cfg;
   logic [127:0] eng_din;
   logic [127:0] eng_iv;
   logic [255:0] eng_key;
   logic         done_flag;

   always #(CLK_P/2) clk = ~clk;

   cipher_regfront u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .reg_wr     (reg_wr),
      .reg_rd     (reg_rd),
      .reg_addr   (reg_addr),
      .reg_wdata  (reg_wdata),
      .reg_rdata  (reg_rdata),
      .eng_start  (eng_start),
      .eng_busy   (eng_busy),
      .eng_done   (eng_done),
      .eng_result (eng_result),
      .eng_cfg    (eng_cfg),
      .eng_din    (eng_din),
      .eng_iv     (eng_iv),
      .eng_key    (eng_key),
      .done_flag  (done_flag)
   );

   // engine stub: fixed latency, result is the bitwise inverse of the input
   logic [127:0] snap;
   int           cnt;
   int           starts = 0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         eng_busy   <= 1'b0;
         eng_done   <= 1'b0;
         eng_result <= '0;
         snap       <= '0;
         cnt        <= 0;
      end else begin
         eng_done <= 1'b0;
         if (eng_start) begin
            eng_busy <= 1'b1;
            cnt      <= LAT;
            snap     <= eng_din;
            starts   <= starts + 1;
         end else if (eng_busy) begin
            if (cnt == 1) begin
               eng_busy   <= 1'b0;
               eng_done   <= 1'b1;
               eng_result <= ~snap;
            end
            cnt <= cnt - 1;
         end
      end
   end

   int checks = 0;
   int fails  = 0;

   task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk); #1;
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, input string tag, input logic [31:0] exp);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a;
      #1 chk(tag, 256'(reg_rdata), 256'(exp));
      @(posedge clk); #1;
      reg_rd = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // vector table: {write, address, data-or-expected}
   localparam int NV = 19;
   localparam logic [37:0] VEC [NV] = '{
      {1'b1, 5'h00, 32'hFFFF_FFFC},
      {1'b0, 5'h00, 32'h000F_7FFC},
      {1'b1, 5'h00, 32'h0000_0000},
      {1'b0, 5'h00, 32'h0000_0000},
      {1'b1, 5'h03, 32'hFFFF_FFFE},
      {1'b0, 5'h03, 32'h0000_0002},
      {1'b1, 5'h04, 32'hAAAA_0002},
      {1'b1, 5'h04, 32'hAAAA_0003},
      {1'b1, 5'h04, 32'hAAAA_0000},
      {1'b0, 5'h03, 32'h0000_0001},
      {1'b1, 5'h03, 32'h0000_0000},
      {1'b0, 5'h04, 32'hAAAA_0000},
      {1'b0, 5'h04, 32'h0000_0000},
      {1'b0, 5'h04, 32'hAAAA_0002},
      {1'b0, 5'h04, 32'hAAAA_0003},
      {1'b0, 5'h03, 32'h0000_0000},
      {1'b1, 5'h08, 32'hCAFE_0000},
      {1'b0, 5'h08, 32'h0000_0000},
      {1'b0, 5'h02, 32'h0000_0000}
   };

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin : stim
      idle(3);
      rst_n = 1'b1;
      idle(2);

      // reset state
      rd(5'h00, "R7 reset config", 32'h0);
      rd(5'h02, "R9 reset flag", 32'h0);
      rd(5'h03, "R1 reset pointer", 32'h0);
      chk("R4 reset start", 256'(eng_start), 256'(0));
      chk("R8 reset key", eng_key, '0);

      // table walk: config storage, pointer, data port, iv read-back
      for (int i = 0; i < NV; i++) begin
         string tag;
         tag = (VEC[i][36:32] == 5'h00) ? "R7 table" :
               (VEC[i][36:32] == 5'h08) ? "R8 table" :
               (VEC[i][36:32] == 5'h02) ? "R9 table" : "R1 table";
         if (VEC[i][37]) wr(VEC[i][36:32], VEC[i][31:0]);
         else            rd(VEC[i][36:32], tag, VEC[i][31:0]);
      end
      chk("R8 iv drives engine", 256'(eng_iv[31:0]), 256'(32'hCAFE_0000));

      // key words in replace mode
      for (int k = 0; k < 8; k++) wr(5'(16 + k), 32'h1100_0000 + k);
      chk("R10 replace key1", 256'(eng_key[63:32]), 256'(32'h1100_0001));
      rd(5'h10, "R8 key read zero", 32'h0);

      // manual start
      wr(5'h00, 32'h0000_0002);
      wr(5'h03, 32'h0);
      for (int k = 0; k < 4; k++) wr(5'h04, 32'h1000_0000 + k * 32'h111);
      chk("R2 buffer to engine", 256'(eng_din[127:96]), 256'(32'h1000_0333));
      chk("R4 no auto start in manual", 256'(starts), 256'(0));
      wr(5'h01, 32'h1);
      rd(5'h04, "R3 blank while busy", 32'h0);
      wr(5'h01, 32'h1);
      idle(20);
      chk("R12 go while busy ignored", 256'(starts), 256'(1));
      rd(5'h02, "R9 flag set on done", 32'h1);
      wr(5'h03, 32'h0);
      for (int k = 0; k < 4; k++)
         rd(5'h04, "R2 result in place", ~(32'h1000_0000 + k * 32'h111));

      // flag write-one-to-clear
      wr(5'h02, 32'h0);
      rd(5'h02, "R9 write zero keeps flag", 32'h1);
      wr(5'h02, 32'h1);
      rd(5'h02, "R9 write one clears", 32'h0);

      // manual go clears a set flag
      wr(5'h01, 32'h1);
      idle(20);
      chk("R9 done_flag output", 256'(done_flag), 256'(1));
      wr(5'h01, 32'h1);
      rd(5'h02, "R4 go clears flag", 32'h0);
      idle(20);
      chk("R4 start count", 256'(starts), 256'(3));

      // lock while enabled
      wr(5'h00, 32'h000F_7FFE);
      rd(5'h00, "R6 locked fields", 32'h0000_0002);

      // go ignored while disabled
      wr(5'h00, 32'h0);
      rd(5'h00, "R6 enable clears", 32'h0);
      wr(5'h01, 32'h1);
      idle(4);
      chk("R12 go while disabled", 256'(starts), 256'(3));

      // automatic start with new-message restart of the fill count
      wr(5'h00, 32'h0000_0802);
      wr(5'h03, 32'h0);
      for (int k = 0; k < 3; k++) wr(5'h04, 32'h2000_0000 + k);
      idle(3);
      chk("R5 three writes no start", 256'(starts), 256'(3));
      wr(5'h01, 32'h2);
      for (int k = 3; k < 6; k++) wr(5'h04, 32'h2000_0000 + k);
      idle(3);
      chk("R5 newmsg restarts count", 256'(starts), 256'(3));
      wr(5'h04, 32'h2000_0006);
      idle(20);
      chk("R5 fourth write starts", 256'(starts), 256'(4));
      rd(5'h04, "R5 auto result word3", ~32'h2000_0003);
      rd(5'h04, "R5 auto result word0", ~32'h2000_0004);

      // XOR key mode
      wr(5'h00, 32'h0);
      wr(5'h00, 32'h0000_4000);
      wr(5'h10, 32'h0000_FFFF);
      chk("R10 xor into key0", 256'(eng_key[31:0]), 256'(32'h1100_FFFF));
      wr(5'h00, 32'h0);
      wr(5'h10, 32'h0000_1234);
      chk("R10 replace key0", 256'(eng_key[31:0]), 256'(32'h0000_1234));

      // soft reset
      wr(5'h00, 32'h0000_0802);
      wr(5'h03, 32'h2);
      rd(5'h02, "R9 flag before soft reset", 32'h1);
      wr(5'h00, 32'h0000_0001);
      rd(5'h00, "R11 config cleared", 32'h0);
      rd(5'h02, "R11 flag cleared", 32'h0);
      rd(5'h03, "R11 pointer cleared", 32'h0);
      rd(5'h04, "R11 buffer cleared", 32'h0);
      chk("R11 key cleared", eng_key, '0);
      chk("R11 iv cleared", 256'(eng_iv), '0);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule